// File: doc/BRIEF.md
# Rotate Unit with Carry

This block rotates a 16-bit or 32-bit word by a programmable count and keeps a single carry flag between operations. Four operations are offered: plain rotate left, plain rotate right, rotate left through carry and rotate right through carry. In the plain forms the word circulates on itself, and the carry records the last bit that crossed the word boundary. In the through-carry forms the carry is an extra bit in the ring, so the ring is 17 or 33 bits long.

The surrounding logic presents the word, selects the width, count and operation, and raises a request. The whole rotation is done in one cycle. Result, carry and a done strobe appear on the registered outputs exactly one clock after the edge at which the request is accepted. In level mode the request is accepted on every cycle in which it is high. In pulse mode it is accepted only on a low-to-high transition. The block does not store the word. It does keep the carry, which the next through-carry operation uses. A count outside the legal range for the selected width raises an error together with done, and it changes neither the carry nor the word.

Top module: `rotcarry_unit`

## Requirements
- R1: A synchronous reset (`rst` high) clears the carry, done, error and the output word, and clears the request-edge memory. As a result, a request that is already high when reset ends is accepted once on the first clock after release, even in pulse mode.
- R2: Operation code 2'b00 rotates the word left by n positions within the selected width. The new carry equals bit 0 of the result.
- R3: Operation code 2'b01 rotates the word right by n positions within the selected width. The new carry equals the top bit of the result (bit 15 or bit 31).
- R4: Operation code 2'b10 rotates left by n positions through a ring of width+1 bits. In that ring the carry sits directly above the word's top bit.
- R5: Operation code 2'b11 rotates right by n positions through the same width+1 bit ring, with the carry directly above the word's top bit.
- R6: When `wide` is 0, only `data_in[15:0]` is used and `data_out[31:16]` is 0. When `wide` is 1, the word is 32 bits, with the low half on bits 15:0 and the high half on bits 31:16, and bits cross between the halves.
- R7: The legal count is 1..16 when `wide` is 0 and 1..32 when `wide` is 1. For any other count, an accepted request raises `err` together with `done`, drives the masked input word unchanged on `data_out`, and leaves the carry unchanged.
- R8: The outputs update one clock after the edge at which a request is accepted. `done` is high for exactly that cycle.
- R9: With `pulse_mode` 0, an operation is performed on every clock edge at which `req` is high. Each operation uses the carry left by the previous one.
- R10: With `pulse_mode` 1, a single operation is performed per low-to-high transition of `req`, however long `req` then stays high.
- R11: While no request is accepted, `data_out` and `carry_out` hold their values and `done` and `err` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| data_in | input | 32 | Word to rotate (bits 15:0 only in narrow mode) |
| wide | input | 1 | 1 selects 32-bit width, 0 selects 16-bit width |
| count | input | 6 | Rotate count n |
| op | input | 2 | 00 left, 01 right, 10 left through carry, 11 right through carry |
| req | input | 1 | Execute request |
| pulse_mode | input | 1 | 1 accepts only rising edges of req |
| data_out | output | 32 | Rotated word, registered |
| carry_out | output | 1 | Carry flag, registered and persistent |
| done | output | 1 | One-cycle strobe marking a fresh result |
| err | output | 1 | Illegal count flag, high together with done |

## Verification
The case hardest to reach from the ports is a chain of through-carry operations in level mode. There, each result depends on a carry that was produced inside the block on the previous edge. The stimulus holds `req` high for several cycles with a constant word and compares every cycle against a bit-serial model that carries its own flag forward. A second hard corner is the edge memory across reset. To reach it, the request is held high in pulse mode while reset is released, and the bench expects exactly one accepted operation.

// File: rtl/rc_pkg.sv
`timescale 1ns/1ps
package rc_pkg;

    localparam int NARROW_W = 16;
    localparam int WIDE_W   = 2 * NARROW_W;
    localparam int CNT_W    = $clog2(WIDE_W) + 1;

    typedef enum logic [1:0] {
        OP_ROL = 2'b00,
        OP_ROR = 2'b01,
        OP_RCL = 2'b10,
        OP_RCR = 2'b11
    } rot_op_e;

    typedef struct packed {
        logic [WIDE_W-1:0] word;
        logic              carry;
        logic              done;
        logic              err;
        logic              req_prev;
    } rot_state_t;

endpackage

// File: rtl/rc_fire_gate.sv
`timescale 1ns/1ps
// Decides whether the request is accepted on this edge.
module rc_fire_gate (
    input  logic req_i,
    input  logic req_prev_i,
    input  logic pulse_mode_i,
    output logic fire_o
);
    always_comb begin
        if (pulse_mode_i) fire_o = req_i && !req_prev_i;
        else              fire_o = req_i;
    end
endmodule

// File: rtl/rc_count_check.sv
`timescale 1ns/1ps
// Legal count window for the selected width.
module rc_count_check #(
    parameter int NARROW = 16,
    parameter int WIDE   = 32,
    parameter int CW     = 6
) (
    input  logic [CW-1:0] count_i,
    input  logic          wide_i,
    output logic          legal_o
);
    localparam logic [CW-1:0] LIM_N = CW'(NARROW);
    localparam logic [CW-1:0] LIM_W = CW'(WIDE);

    logic [CW-1:0] limit;

    always_comb begin
        limit   = wide_i ? LIM_W : LIM_N;
        legal_o = (count_i != '0) && (count_i <= limit);
    end
endmodule

// File: rtl/rc_rotator.sv
`timescale 1ns/1ps
// Single-cycle rotator of one width, plain and through-carry forms.
module rc_rotator #(
    parameter int W  = 16,
    parameter int CW = 6
) (
    input  logic [W-1:0]  word_i,
    input  logic          carry_i,
    input  logic [CW-1:0] amt_i,
    input  logic          left_i,
    input  logic          thru_i,
    output logic [W-1:0]  word_o,
    output logic          carry_o
);
    localparam int RING = W + 1;

    logic [2*W-1:0]    dbl_l, dbl_r;
    logic [2*RING-1:0] ring_l, ring_r;
    logic [RING-1:0]   ring_sel;

    always_comb begin
        dbl_l  = {word_i, word_i} << amt_i;
        dbl_r  = {word_i, word_i} >> amt_i;
        ring_l = {carry_i, word_i, carry_i, word_i} << amt_i;
        ring_r = {carry_i, word_i, carry_i, word_i} >> amt_i;
        ring_sel = left_i ? ring_l[2*RING-1:RING] : ring_r[RING-1:0];

        if (thru_i) begin
            word_o  = ring_sel[W-1:0];
            carry_o = ring_sel[W];
        end else if (left_i) begin
            word_o  = dbl_l[2*W-1:W];
            carry_o = dbl_l[W];
        end else begin
            word_o  = dbl_r[W-1:0];
            carry_o = dbl_r[W-1];
        end
    end
endmodule

// File: rtl/rotcarry_unit.sv
`timescale 1ns/1ps
module rotcarry_unit
    import rc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WIDE_W-1:0] data_in,
    input  logic              wide,
    input  logic [CNT_W-1:0]  count,
    input  logic [1:0]        op,
    input  logic              req,
    input  logic              pulse_mode,
    output logic [WIDE_W-1:0] data_out,
    output logic              carry_out,
    output logic              done,
    output logic              err
);
    localparam int LANES = 2;

    rot_state_t st_d, st_q;

    logic              fire;
    logic              legal;
    logic              go_left;
    logic              go_thru;
    logic              req_last;
    logic [WIDE_W-1:0] in_mask;
    logic [WIDE_W-1:0] lane_word [LANES];
    logic              lane_carry[LANES];

    assign go_left  = (rot_op_e'(op) == OP_ROL) || (rot_op_e'(op) == OP_RCL);
    assign go_thru  = op[1];
    assign req_last = st_q.req_prev;
    assign in_mask  = wide ? '1 : WIDE_W'({NARROW_W{1'b1}});

    rc_fire_gate u_gate (
        .req_i        (req),
        .req_prev_i   (st_q.req_prev),
        .pulse_mode_i (pulse_mode),
        .fire_o       (fire)
    );

    rc_count_check #(.NARROW(NARROW_W), .WIDE(WIDE_W), .CW(CNT_W)) u_cnt (
        .count_i (count),
        .wide_i  (wide),
        .legal_o (legal)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int GW = (g == 0) ? NARROW_W : WIDE_W;
        logic [GW-1:0] r_word;
        logic          r_carry;

        rc_rotator #(.W(GW), .CW(CNT_W)) u_rot (
            .word_i  (data_in[GW-1:0]),
            .carry_i (st_q.carry),
            .amt_i   (count),
            .left_i  (go_left),
            .thru_i  (go_thru),
            .word_o  (r_word),
            .carry_o (r_carry)
        );

        assign lane_word[g]  = WIDE_W'(r_word);
        assign lane_carry[g] = r_carry;
    end

    always_comb begin
        st_d          = st_q;
        st_d.req_prev = req;
        st_d.done     = 1'b0;
        st_d.err      = 1'b0;
        if (fire) begin
            st_d.done = 1'b1;
            if (legal) begin
                st_d.word  = lane_word[wide];
                st_d.carry = lane_carry[wide];
            end else begin
                st_d.err  = 1'b1;
                st_d.word = data_in & in_mask;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign data_out  = st_q.word;
    assign carry_out = st_q.carry;
    assign done      = st_q.done;
    assign err       = st_q.err;

endmodule

// File: rtl/rc_checker.sv
`timescale 1ns/1ps
module rc_checker (
    input logic        clk,
    input logic        rst,
    input logic [31:0] data_in,
    input logic        wide,
    input logic [5:0]  count,
    input logic [1:0]  op,
    input logic        req,
    input logic        pulse_mode,
    input logic        req_last,
    input logic [31:0] data_out,
    input logic        carry_out,
    input logic        done,
    input logic        err
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (carry_out == 1'b0 && !done && !err));

    // R2
    rol16_full_chk: assert property (@(posedge clk) disable iff (rst)
        (req && !pulse_mode && op == 2'b00 && !wide && count == 6'd16)
        |=> data_out == {16'h0000, $past(data_in[15:0])});

    // R7
    illegal_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (done && err) |-> carry_out == $past(carry_out));

    // R8
    level_done_chk: assert property (@(posedge clk) disable iff (rst)
        (req && !pulse_mode) |=> done);

    // R10
    pulse_once_chk: assert property (@(posedge clk) disable iff (rst)
        (req && pulse_mode && req_last) |=> !done);

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !req |=> (!done && !err && $stable(carry_out) && $stable(data_out)));
endmodule

bind rotcarry_unit rc_checker u_rc_checker (
    .clk        (clk),
    .rst        (rst),
    .data_in    (data_in),
    .wide       (wide),
    .count      (count),
    .op         (op),
    .req        (req),
    .pulse_mode (pulse_mode),
    .req_last   (req_last),
    .data_out   (data_out),
    .carry_out  (carry_out),
    .done       (done),
    .err        (err)
);

// File: tb/test_rotcarry_unit.sv
`timescale 1ns/1ps
module test_rotcarry_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] data_in;
    logic        wide;
    logic [5:0]  count;
    logic [1:0]  op;
    logic        req;
    logic        pulse_mode;
    logic [31:0] data_out;
    logic        carry_out;
    logic        done;
    logic        err;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  finished = 0;
    logic mc;   // bench copy of the carry

    always #10 clk = ~clk;

    rotcarry_unit i_rotcarry_unit (
        .clk(clk), .rst(rst), .data_in(data_in), .wide(wide), .count(count),
        .op(op), .req(req), .pulse_mode(pulse_mode), .data_out(data_out),
        .carry_out(carry_out), .done(done), .err(err)
    );

    function automatic logic [31:0] wmask(input logic w);
        return w ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    endfunction

    // Bit-serial reference: returns {carry, word}
    function automatic logic [32:0] model(input logic [1:0] o, input logic w,
                                          input int n, input logic [31:0] d,
                                          input logic c);
        int          wd = w ? 32 : 16;
        logic [31:0] x  = d & wmask(w);
        logic        b;
        for (int k = 0; k < n; k++) begin
            case (o)
                2'b00: begin b = x[wd-1]; x = ((x << 1) | 32'(b)) & wmask(w); c = b; end
                2'b01: begin b = x[0]; x = (x >> 1) | (32'(b) << (wd-1)); c = b; end
                2'b10: begin b = x[wd-1]; x = ((x << 1) | 32'(c)) & wmask(w); c = b; end
                default: begin b = x[0]; x = (x >> 1) | (32'(c) << (wd-1)); c = b; end
            endcase
        end
        return {c, x};
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic do_op(input string tag, input logic [1:0] o, input logic w,
                         input logic [5:0] n, input logic [31:0] d);
        logic [32:0] e;
        logic        ok;
        @(negedge clk);
        op = o; wide = w; count = n; data_in = d; pulse_mode = 1'b0; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        ok = (n != 0) && (int'(n) <= (w ? 32 : 16));
        e  = ok ? model(o, w, int'(n), d, mc) : {mc, d & wmask(w)};
        chk(tag, "done", 32'(done), 32'd1);
        chk(tag, "err", 32'(err), ok ? 32'd0 : 32'd1);
        chk(tag, "data", data_out, e[31:0]);
        chk(tag, "carry", 32'(carry_out), 32'(e[32]));
        mc = e[32];
    endtask

    task automatic t_reset();
        rst = 1'b1; req = 1'b0; pulse_mode = 1'b0; data_in = '0;
        wide = 1'b0; count = 6'd1; op = 2'b00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        mc = 1'b0;
        chk("R1", "carry", 32'(carry_out), 32'd0);
        chk("R1", "done", 32'(done), 32'd0);
        chk("R1", "data", data_out, 32'd0);
    endtask

    task automatic t_plain();
        do_op("R2", 2'b00, 1'b0, 6'd1,  32'h0000_8001);
        do_op("R2", 2'b00, 1'b0, 6'd16, 32'h0000_1234);
        do_op("R2", 2'b00, 1'b1, 6'd7,  32'hF00D_BEEF);
        do_op("R2", 2'b00, 1'b1, 6'd32, 32'h8000_0001);
        do_op("R3", 2'b01, 1'b0, 6'd4,  32'h0000_000B);
        do_op("R3", 2'b01, 1'b1, 6'd31, 32'h0000_0002);
        do_op("R3", 2'b01, 1'b0, 6'd16, 32'h0000_8000);
    endtask

    task automatic t_thru();
        do_op("R4", 2'b10, 1'b0, 6'd1,  32'h0000_8000);
        do_op("R4", 2'b10, 1'b0, 6'd16, 32'h0000_5A5A);
        do_op("R4", 2'b10, 1'b1, 6'd9,  32'hC001_0FF0);
        do_op("R5", 2'b11, 1'b1, 6'd32, 32'h1357_9BDF);
        do_op("R5", 2'b11, 1'b0, 6'd5,  32'h0000_0013);
        do_op("R5", 2'b11, 1'b1, 6'd1,  32'h0000_0001);
    endtask

    task automatic t_width();
        do_op("R6", 2'b00, 1'b0, 6'd3, 32'hFFFF_E001);
        do_op("R6", 2'b00, 1'b1, 6'd1, 32'h0001_8000);
        chk("R6", "cross", data_out, 32'h0003_0000);
        do_op("R6", 2'b01, 1'b1, 6'd1, 32'h0001_0000);
        chk("R6", "cross", data_out, 32'h0000_8000);
    endtask

    task automatic t_illegal();
        do_op("R4", 2'b10, 1'b0, 6'd1, 32'h0000_8000);   // set carry to 1
        do_op("R7", 2'b10, 1'b0, 6'd0,  32'hABCD_1234);
        do_op("R7", 2'b00, 1'b0, 6'd17, 32'h0000_00F0);
        do_op("R7", 2'b11, 1'b1, 6'd33, 32'h8765_4321);
        do_op("R7", 2'b01, 1'b1, 6'd63, 32'h0F0F_0F0F);
        chk("R7", "carry kept", 32'(carry_out), 32'd1);
    endtask

    task automatic t_latency();
        do_op("R8", 2'b01, 1'b0, 6'd2, 32'h0000_0003);
        @(negedge clk);
        chk("R8", "done single", 32'(done), 32'd0);
    endtask

    task automatic t_repeat();
        logic [32:0] e;
        @(negedge clk);
        op = 2'b10; wide = 1'b0; count = 6'd3; data_in = 32'h0000_A00F;
        pulse_mode = 1'b0; req = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            e = model(2'b10, 1'b0, 3, 32'h0000_A00F, mc);
            chk("R9", "done", 32'(done), 32'd1);
            chk("R9", "data", data_out, e[31:0]);
            chk("R9", "carry", 32'(carry_out), 32'(e[32]));
            mc = e[32];
        end
        req = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_pulse();
        logic [32:0] e;
        int          seen = 0;
        @(negedge clk);
        op = 2'b00; wide = 1'b1; count = 6'd4; data_in = 32'h1234_5678;
        pulse_mode = 1'b1; req = 1'b1;
        e = model(2'b00, 1'b1, 4, 32'h1234_5678, mc);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (done) seen++;
        end
        chk("R10", "fires", 32'(seen), 32'd1);
        chk("R10", "data", data_out, e[31:0]);
        mc = e[32];
        req = 1'b0;
        @(negedge clk);
        req = 1'b1;
        @(negedge clk);
        chk("R10", "re-arm", 32'(done), 32'd1);
        mc = model(2'b00, 1'b1, 4, 32'h1234_5678, mc) >> 32;
        req = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_hold();
        logic [31:0] d0;
        logic        c0;
        @(negedge clk);
        d0 = data_out; c0 = carry_out;
        data_in = 32'hDEAD_BEEF; count = 6'd5; op = 2'b11; req = 1'b0;
        repeat (3) @(negedge clk);
        chk("R11", "data", data_out, d0);
        chk("R11", "carry", 32'(carry_out), 32'(c0));
        chk("R11", "done", 32'(done), 32'd0);
    endtask

    task automatic t_reset_pulse();
        @(negedge clk);
        rst = 1'b1; pulse_mode = 1'b1; req = 1'b1;
        op = 2'b01; wide = 1'b0; count = 6'd1; data_in = 32'h0000_0001;
        repeat (2) @(negedge clk);
        chk("R1", "carry cleared", 32'(carry_out), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "fires after reset", 32'(done), 32'd1);
        chk("R1", "data", data_out, 32'h0000_8000);
        @(negedge clk);
        chk("R1", "once", 32'(done), 32'd0);
        req = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        mc = 1'b0;
        t_reset();
        t_plain();
        t_thru();
        t_width();
        t_illegal();
        t_latency();
        t_repeat();
        t_pulse();
        t_hold();
        t_reset_pulse();
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule